// File: doc/BRIEF.md
# Host Command Request Receiver over SPI

This block is the receive side of a command channel in which an external host talks to the chip over SPI. The chip is the target, and the link runs in mode 0 with 8-bit frames, most significant bit first. The host never announces how many bytes it will send. The receiver therefore reads an 8-byte request header, checks it, and works out from it how long the whole request is. Every byte of the request is written into a local request buffer. When the last byte arrives, a one-cycle `req_valid` pulse tells the command processor that a request is ready. The processor then reads the buffer through a plain read port.

While the host clocks a byte in, the block clocks one status byte out on MISO, so the host can always tell what the block is doing. The block has seven states: off, not ready, ready, receiving, processing, sending, and failed. The response framer signals through `rsp_start` that it has taken over the response, and through `rsp_done` that the response is finished. The SPI pins are oversampled by the system clock through two-stage synchronisers.

A receive fails if the request would overflow the buffer, or if it takes longer than a fixed timeout counted from the system clock. Once a receive has failed, the block ignores the host until chip select goes high again.

Top module: `hcmd_spi_rx`

## Requirements
- R1: Each byte slot returns one status byte on MISO, MSB first. The status for a slot is latched before the slot's first bit. The codes are: 0x78 ready, 0xF9 receiving, 0xFA processing or sending, 0xFB request too long, and 0xFC not ready or timed out. While chip select is high, MISO shows the MSB of the current status, which is 0 when ready.
- R2: While `enable` is low the block is off. It stores nothing, raises no `req_valid`, and returns 0xFC. When `enable` rises with chip select high, the block becomes ready. When `enable` rises with chip select low, the block becomes not ready.
- R3: The header layout is: byte 0 protocol version, byte 1 checksum, bytes 2–3 command, byte 4 command version, byte 5 reserved, bytes 6–7 data length (little endian). The expected length is 8 plus the data length, but only when the version is 3 and the reserved byte is 0. Otherwise the expected length is 0.
- R4: Once the received count reaches the larger of 8 and the expected length, the block pulses `req_valid` for one cycle and sets `req_len` to the expected length. The block then enters processing, and the following slots return 0xFA.
- R5: Request byte n is stored at buffer address n and can be read on `buf_rdata` for address `buf_raddr`. The write pointer never exceeds BUF_BYTES.
- R6: An expected length greater than BUF_BYTES makes the receive fail with status 0xFB, and no `req_valid` follows.
- R7: If a receive stays incomplete for TICKS_PER_US×TIMEOUT_US clock cycles, the block pulses `rx_err`, fails, and returns 0xFC.
- R8: Chip select going high in any enabled state other than processing moves the block to ready. This rewinds the write pointer and drops any partial byte, so the next request is stored from address 0.
- R9: Chip select going high during processing is remembered. When `rsp_done` ends the sending state, the block becomes ready if chip select went high during processing. Otherwise the block becomes not ready (0xFC) until chip select goes high.
- R10: A chip-select assertion while the block is not ready or failed leaves it returning 0xFC. Bytes clocked in while the block is not receiving are never written to the buffer.
- R11: `rsp_start` moves the block from processing to sending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Receiver enable |
| spi_sck | input | 1 | SPI clock from host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Host-to-target data |
| spi_miso | output | 1 | Status byte stream to host |
| rsp_start | input | 1 | Response framer has taken the response |
| rsp_done | input | 1 | Response framer has finished |
| req_valid | output | 1 | One-cycle pulse: request complete |
| req_len | output | 17 | Expected request length (0 for a rejected header) |
| rx_err | output | 1 | One-cycle pulse on receive timeout |
| buf_raddr | input | $clog2(BUF_BYTES+1) | Request buffer read address |
| buf_rdata | output | 8 | Request buffer read data |

## Verification
Some properties are checked on every cycle:
- The write pointer stays within the buffer, and every buffer write address is in range.
- `req_valid` only appears on the step from receiving into processing.
- The pointer does not move while processing.
- A timeout lands the block in the failed state with the timeout code selected.
- Chip select going high outside processing returns the block to ready with a rewound pointer.
- The prescaled timer stays in range.

The bench scenarios cover what no single-cycle property can show:
- the status byte sequence the host sees across whole transactions;
- the header validity and length rules;
- buffer contents surviving polling traffic;
- the choice between deferred and immediate readiness after a response;
- recovery after an abort, an oversize header and a timeout.

// File: rtl/hcmd_pkg.sv
`timescale 1ns/1ps
package hcmd_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_NRDY,
    ST_RDY,
    ST_RECV,
    ST_PROC,
    ST_SEND,
    ST_BAD
  } rx_state_e;

  localparam logic [7:0] STAT_READY  = 8'h78;
  localparam logic [7:0] STAT_RECV   = 8'hF9;
  localparam logic [7:0] STAT_PROC   = 8'hFA;
  localparam logic [7:0] STAT_BADLEN = 8'hFB;
  localparam logic [7:0] STAT_NRDY   = 8'hFC;

  localparam int HDR_BYTES = 8;
  localparam logic [7:0] PROTO_VER = 8'd3;
  localparam int LEN_W = 17;

  function automatic logic [7:0] status_code(rx_state_e st, logic badlen);
    case (st)
      ST_RDY:  return STAT_READY;
      ST_RECV: return STAT_RECV;
      ST_PROC: return STAT_PROC;
      ST_SEND: return STAT_PROC;
      ST_BAD:  return badlen ? STAT_BADLEN : STAT_NRDY;
      default: return STAT_NRDY;
    endcase
  endfunction

endpackage

// File: rtl/hcmd_spi_front.sv
`timescale 1ns/1ps
module hcmd_spi_front (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck_i,
  input  logic       cs_n_i,
  input  logic       mosi_i,
  output logic       cs_act,
  output logic       cs_on,
  output logic       cs_off,
  output logic       byte_vld,
  output logic [7:0] byte_data,
  output logic [2:0] bit_idx
);

  logic [1:0] sck_sy, cs_sy, mosi_sy;
  logic       sck_p, act_p, rise;
  logic [6:0] sh_q, sh_d;
  logic [2:0] bit_d;

  always_comb begin
    cs_act    = ~cs_sy[1];
    rise      = sck_sy[1] & ~sck_p;
    cs_on     = cs_act & ~act_p;
    cs_off    = ~cs_act & act_p;
    byte_vld  = rise & cs_act & (bit_idx == 3'd7);
    byte_data = {sh_q, mosi_sy[1]};
    bit_d     = bit_idx;
    sh_d      = sh_q;
    if (!cs_act) begin
      bit_d = 3'd0;
      sh_d  = 7'd0;
    end else if (rise) begin
      bit_d = bit_idx + 3'd1;
      sh_d  = {sh_q[5:0], mosi_sy[1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy  <= 2'b00;
      cs_sy   <= 2'b11;
      mosi_sy <= 2'b00;
      sck_p   <= 1'b0;
      act_p   <= 1'b0;
      sh_q    <= 7'd0;
      bit_idx <= 3'd0;
    end else begin
      sck_sy  <= {sck_sy[0], sck_i};
      cs_sy   <= {cs_sy[0], cs_n_i};
      mosi_sy <= {mosi_sy[0], mosi_i};
      sck_p   <= sck_sy[1];
      act_p   <= cs_act;
      sh_q    <= sh_d;
      bit_idx <= bit_d;
    end
  end

endmodule

// File: rtl/hcmd_hdr_parse.sv
`timescale 1ns/1ps
module hcmd_hdr_parse
  import hcmd_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cap,
  input  logic [AW-1:0]    pos,
  input  logic [7:0]       din,
  output logic [LEN_W-1:0] exp_len
);

  logic [7:0] ver_q, rsv_q, lo_q, hi_q, hi_fwd;
  logic       hdr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ver_q <= 8'd0;
      rsv_q <= 8'd0;
      lo_q  <= 8'd0;
      hi_q  <= 8'd0;
    end else if (clr) begin
      ver_q <= 8'd0;
      rsv_q <= 8'd0;
      lo_q  <= 8'd0;
      hi_q  <= 8'd0;
    end else if (cap) begin
      if (pos == AW'(0)) ver_q <= din;
      if (pos == AW'(5)) rsv_q <= din;
      if (pos == AW'(6)) lo_q  <= din;
      if (pos == AW'(7)) hi_q  <= din;
    end
  end

  always_comb begin
    hi_fwd  = (cap && pos == AW'(7)) ? din : hi_q;
    hdr_ok  = (ver_q == PROTO_VER) && (rsv_q == 8'd0);
    exp_len = hdr_ok ? (LEN_W'(HDR_BYTES) + LEN_W'({hi_fwd, lo_q})) : '0;
  end

endmodule

// File: rtl/hcmd_req_buf.sv
`timescale 1ns/1ps
module hcmd_req_buf #(
  parameter int DEPTH = 544,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_comb begin
    rdata = (raddr < AW'(DEPTH)) ? mem[raddr] : 8'd0;
  end

  a_r5_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (waddr < AW'(DEPTH)));

endmodule

// File: rtl/hcmd_rx_timer.sv
`timescale 1ns/1ps
module hcmd_rx_timer #(
  parameter int TICKS_PER_US = 50,
  parameter int TIMEOUT_US   = 8192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tmo
);

  localparam int PW = $clog2(TICKS_PER_US + 1);
  localparam int UW = $clog2(TIMEOUT_US + 1);

  logic [PW-1:0] pre_q, pre_d;
  logic [UW-1:0] us_q, us_d;
  logic          wrap;

  always_comb begin
    wrap  = (pre_q == PW'(TICKS_PER_US - 1));
    tmo   = run && wrap && (us_q == UW'(TIMEOUT_US - 1));
    pre_d = pre_q;
    us_d  = us_q;
    if (!run) begin
      pre_d = '0;
      us_d  = '0;
    end else if (wrap) begin
      pre_d = '0;
      us_d  = us_q + UW'(1);
    end else begin
      pre_d = pre_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      us_q  <= '0;
    end else begin
      pre_q <= pre_d;
      us_q  <= us_d;
    end
  end

  a_r7_us_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (us_q < UW'(TIMEOUT_US)));

endmodule

// File: rtl/hcmd_spi_rx.sv
`timescale 1ns/1ps
module hcmd_spi_rx
  import hcmd_pkg::*;
#(
  parameter int BUF_BYTES    = 544,
  parameter int TICKS_PER_US = 50,
  parameter int TIMEOUT_US   = 8192,
  localparam int AW          = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             spi_sck,
  input  logic             spi_cs_n,
  input  logic             spi_mosi,
  output logic             spi_miso,
  input  logic             rsp_start,
  input  logic             rsp_done,
  output logic             req_valid,
  output logic [LEN_W-1:0] req_len,
  output logic             rx_err,
  input  logic [AW-1:0]    buf_raddr,
  output logic [7:0]       buf_rdata
);

  logic             cs_act, cs_on, cs_off, byte_vld, tmo, we, cap;
  logic [7:0]       byte_data, stat_q;
  logic [2:0]       bit_idx;
  logic [LEN_W-1:0] exp_len, rlen_q, rlen_d;
  rx_state_e        state_q, state_d;
  logic [AW-1:0]    wptr_q, wptr_d, cnt_n;
  logic             defer_q, defer_d, badlen_q, badlen_d;
  logic             reqv_q, reqv_d, err_q, err_d;

  hcmd_spi_front u_front (
    .clk(clk), .rst_n(rst_n), .sck_i(spi_sck), .cs_n_i(spi_cs_n), .mosi_i(spi_mosi),
    .cs_act(cs_act), .cs_on(cs_on), .cs_off(cs_off), .byte_vld(byte_vld),
    .byte_data(byte_data), .bit_idx(bit_idx)
  );

  hcmd_hdr_parse #(.AW(AW)) u_hdr (
    .clk(clk), .rst_n(rst_n), .clr(state_q != ST_RECV), .cap(cap),
    .pos(wptr_q), .din(byte_data), .exp_len(exp_len)
  );

  hcmd_req_buf #(.DEPTH(BUF_BYTES), .AW(AW)) u_buf (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(wptr_q), .wdata(byte_data),
    .raddr(buf_raddr), .rdata(buf_rdata)
  );

  hcmd_rx_timer #(.TICKS_PER_US(TICKS_PER_US), .TIMEOUT_US(TIMEOUT_US)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(state_q == ST_RECV), .tmo(tmo)
  );

  always_comb begin
    cap      = enable && (state_q == ST_RECV) && byte_vld;
    we       = cap && (wptr_q < AW'(BUF_BYTES));
    cnt_n    = wptr_q + AW'(1);
    state_d  = state_q;
    wptr_d   = wptr_q;
    defer_d  = defer_q;
    badlen_d = badlen_q;
    rlen_d   = rlen_q;
    reqv_d   = 1'b0;
    err_d    = 1'b0;
    if (we) wptr_d = cnt_n;
    if (!enable) begin
      state_d = ST_OFF;
    end else begin
      case (state_q)
        ST_OFF:  state_d = cs_act ? ST_NRDY : ST_RDY;
        ST_NRDY: if (cs_off) state_d = ST_RDY;
                 else if (cs_on) begin state_d = ST_BAD; badlen_d = 1'b0; end
        ST_RDY:  if (cs_on) state_d = ST_RECV;
        ST_RECV: begin
          if (cs_off) begin
            state_d = ST_RDY;
          end else if (tmo) begin
            state_d  = ST_BAD;
            badlen_d = 1'b0;
            err_d    = 1'b1;
          end else if (byte_vld && cnt_n >= AW'(HDR_BYTES)) begin
            if (exp_len > LEN_W'(BUF_BYTES)) begin
              state_d  = ST_BAD;
              badlen_d = 1'b1;
            end else if (LEN_W'(cnt_n) >= exp_len) begin
              state_d = ST_PROC;
              reqv_d  = 1'b1;
              rlen_d  = exp_len;
            end
          end
        end
        ST_PROC: begin
          if (cs_off) defer_d = 1'b1;
          if (rsp_start) state_d = ST_SEND;
        end
        ST_SEND: if (cs_off) state_d = ST_RDY;
                 else if (rsp_done) state_d = defer_q ? ST_RDY : ST_NRDY;
        ST_BAD:  if (cs_off) state_d = ST_RDY;
        default: state_d = ST_OFF;
      endcase
    end
    if (state_d == ST_RDY) begin
      wptr_d  = '0;
      defer_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_OFF;
      wptr_q   <= '0;
      defer_q  <= 1'b0;
      badlen_q <= 1'b0;
      rlen_q   <= '0;
      reqv_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      wptr_q   <= wptr_d;
      defer_q  <= defer_d;
      badlen_q <= badlen_d;
      rlen_q   <= rlen_d;
      reqv_q   <= reqv_d;
      err_q    <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= STAT_NRDY;
    else if (!cs_act || bit_idx == 3'd0) stat_q <= status_code(state_q, badlen_q);
  end

  assign spi_miso  = stat_q[3'd7 - bit_idx];
  assign req_valid = reqv_q;
  assign req_len   = rlen_q;
  assign rx_err    = err_q;

  a_r5_wptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    wptr_q <= AW'(BUF_BYTES));

  a_r4_req_from_recv: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (state_q == ST_PROC) && ($past(state_q) == ST_RECV));

  a_r10_proc_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PROC) |=> (state_q != ST_PROC) || $stable(wptr_q));

  a_r7_err_to_bad: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |-> (state_q == ST_BAD) && !badlen_q);

  a_r8_release_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_off && enable && state_q != ST_PROC && state_q != ST_OFF)
      |=> (state_q == ST_RDY) && (wptr_q == '0));

endmodule

// File: tb/hcmd_spi_rx_tb.sv
`timescale 1ns/1ps
module hcmd_spi_rx_tb;

  localparam int BUFB = 544;
  localparam int TPU  = 10;
  localparam int TMO  = 400;
  localparam int HALF = 8;
  localparam int AW   = $clog2(BUFB + 1);

  logic clk, rst_n, enable, sck, cs_n, mosi, rsp_start, rsp_done;
  logic [AW-1:0] raddr;
  logic miso, req_valid, rx_err;
  logic [16:0] req_len;
  logic [7:0] rdata;

  int checks = 0, fails = 0, n_req = 0, n_err = 0, n_mon = 0;
  int exp_len_q[$];
  logic [7:0] exp_byte_q[$];
  logic [7:0] pkt[$];
  bit done_flag = 0;

  hcmd_spi_rx #(.BUF_BYTES(BUFB), .TICKS_PER_US(TPU), .TIMEOUT_US(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .spi_sck(sck), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .rsp_start(rsp_start), .rsp_done(rsp_done),
    .req_valid(req_valid), .req_len(req_len), .rx_err(rx_err),
    .buf_raddr(raddr), .buf_rdata(rdata)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic half_bit();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      half_bit();
      sck = 1'b1;
      rx[i] = miso;
      half_bit();
      sck = 1'b0;
    end
  endtask

  task automatic cs_low();
    cs_n = 1'b0;
    half_bit();
  endtask

  task automatic cs_high();
    half_bit();
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic build(logic [7:0] ver, logic [7:0] rsv, int dlen, int total, int seed);
    pkt.delete();
    pkt.push_back(ver);  pkt.push_back(8'h5A); pkt.push_back(8'h21);
    pkt.push_back(8'h00); pkt.push_back(8'h01); pkt.push_back(rsv);
    pkt.push_back(dlen[7:0]); pkt.push_back(dlen[15:8]);
    for (int i = 0; i < total - 8; i++) pkt.push_back(8'(i * 37 + seed));
  endtask

  task automatic push_exp(int len);
    exp_len_q.push_back(len);
    for (int i = 0; i < len; i++) exp_byte_q.push_back(pkt[i]);
  endtask

  task automatic send_bytes(int n, string tag);
    logic [7:0] r;
    for (int i = 0; i < n; i++) begin
      xfer(pkt[i], r);
      chk(tag, r, 8'hF9);
    end
  endtask

  task automatic poll(logic [7:0] exp, string tag);
    logic [7:0] r;
    xfer(8'h33, r);
    chk(tag, r, exp);
  endtask

  task automatic finish_rsp(bit deferred);
    int m;
    m = n_mon;
    if (deferred) cs_high();
    @(negedge clk) rsp_start = 1'b1;
    @(negedge clk) rsp_start = 1'b0;
    while (n_mon == m) @(negedge clk);
    @(negedge clk) rsp_done = 1'b1;
    @(negedge clk) rsp_done = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // Scoreboard monitor: pops expected requests as the design presents them
  initial begin
    int el;
    logic [7:0] eb;
    forever begin
      @(posedge clk); #2;
      if (req_valid) begin
        n_req++;
        el = 0;
        if (exp_len_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R4 unexpected request actual=%0h expected=none", req_len);
        end else begin
          el = exp_len_q.pop_front();
          chk("R4 req_len", int'(req_len), el);
        end
        while (!rsp_start) begin @(posedge clk); #2; end
        for (int a = 0; a < el; a++) begin
          raddr = AW'(a);
          #2;
          eb = exp_byte_q.pop_front();
          chk("R5 R10 buffer byte", rdata, eb);
        end
        n_mon++;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk); #2;
      if (rx_err) n_err++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int nr, ne;
    logic [7:0] r;
    rst_n = 0; enable = 0; sck = 0; cs_n = 1; mosi = 0;
    rsp_start = 0; rsp_done = 0; raddr = '0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk("reset req_valid", req_valid, 0);
    chk("reset rx_err", rx_err, 0);

    // R2: disabled block returns not-ready
    chk("R2 idle miso while off", miso, 1);
    cs_low(); xfer(8'h03, r); chk("R2 status while off", r, 8'hFC); cs_high();
    chk("R2 no request while off", n_req, 0);
    enable = 1; repeat (5) @(negedge clk);
    chk("R1 R2 idle miso ready", miso, 0);

    // R3 R4 R5 R9: valid request, release during processing -> deferred ready
    build(8'd3, 8'd0, 6, 14, 11); push_exp(14);
    cs_low(); send_bytes(14, "R1 receiving status");
    poll(8'hFA, "R4 processing status");
    poll(8'hFA, "R10 R11 polling while processing");
    finish_rsp(1);
    chk("R9 deferred ready idle miso", miso, 0);

    // R9: no release during processing -> not ready afterwards
    build(8'd3, 8'd0, 0, 8, 5); push_exp(8);
    cs_low(); send_bytes(8, "R3 header only status");
    poll(8'hFA, "R4 header-only completes");
    finish_rsp(0);
    poll(8'hFC, "R9 not ready after response");
    cs_high();
    chk("R8 ready after release", miso, 0);

    // R3: bad version and nonzero reserved give length 0
    build(8'd2, 8'd0, 4, 8, 7); push_exp(0);
    cs_low(); send_bytes(8, "R3 bad version status");
    poll(8'hFA, "R3 bad version completes at header");
    finish_rsp(1);
    build(8'd3, 8'd1, 4, 8, 9); push_exp(0);
    cs_low(); send_bytes(8, "R3 reserved status");
    poll(8'hFA, "R3 reserved completes at header");
    finish_rsp(1);

    // R6: oversize header
    nr = n_req;
    build(8'd3, 8'd0, 600, 8, 3);
    cs_low(); send_bytes(8, "R6 header status");
    poll(8'hFB, "R6 oversize status");
    poll(8'hFB, "R6 oversize status held");
    cs_high();
    chk("R6 no request after oversize", n_req, nr);
    chk("R8 ready after oversize", miso, 0);

    // R8: abort mid-request, then a full request lands at address 0
    build(8'd3, 8'd0, 10, 18, 1);
    cs_low(); send_bytes(5, "R8 partial status"); cs_high();
    build(8'd3, 8'd0, 3, 11, 77); push_exp(11);
    cs_low(); send_bytes(11, "R8 R5 rewind status");
    poll(8'hFA, "R8 rewind completes");
    finish_rsp(1);

    // R7: timeout
    nr = n_req; ne = n_err;
    build(8'd3, 8'd0, 50, 10, 2);
    cs_low(); send_bytes(10, "R7 slow request status");
    repeat (TPU * TMO) @(negedge clk);
    chk("R7 rx_err pulse count", n_err, ne + 1);
    poll(8'hFC, "R7 status after timeout");
    cs_high();
    chk("R7 no request after timeout", n_req, nr);

    // R10: chip select already low when enabled -> not ready, ignored
    enable = 0; repeat (4) @(negedge clk);
    cs_low(); enable = 1; repeat (6) @(negedge clk);
    poll(8'hFC, "R10 not ready status");
    poll(8'hFC, "R10 not ready status held");
    cs_high();
    chk("R10 no request while not ready", n_req, nr);

    // recovery
    build(8'd3, 8'd0, 2, 10, 41); push_exp(10);
    cs_low(); send_bytes(10, "R1 recovery status");
    poll(8'hFA, "R4 recovery completes");
    finish_rsp(1);
    chk("R4 all expected requests seen", exp_len_q.size(), 0);

    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule